// File: doc/BRIEF.md
# Six-Switch Gate Steering Stage

This block sits between a PWM carrier comparator and the gate drivers of a three-leg inverter. It takes a single PWM waveform and sends it to exactly one of six power switches, while a second switch, chosen for the current commutation step, is held fully on so that current can flow through two motor windings. The routing is chosen either from a six-step commutation index or from an explicit pair of switch indices. The choice takes effect only when a commutation pulse arrives.

Each leg has a high-side and a low-side switch. A programmable dead time delays every turn-on edge, and turn-off edges pass with no added delay. The block never turns on both switches of one leg together. A per-output polarity mask sets the active level of each gate output. A master enable drives every output to its inactive level on the next clock.

Top module: `gate_steer`

## Requirements
- R1: While `rst` is high, and on the first clock after it, each `gate` bit equals its `pol` bit (inactive). No switch is driven until the first `commute` pulse after reset.
- R2: Switch index 2*k is the high side and 2*k+1 the low side of leg k (k = 0, 1, 2). In step mode (`use_pattern`=0), step s in 0..5 gives PWM to the high side of leg s>>1. It holds on the low side of leg ((s>>1)+1+s[0]) mod 3. This yields gate masks 6'b001001, 6'b100001, 6'b100100, 6'b000110, 6'b010010 and 6'b011000 for steps 0 to 5 with PWM high.
- R3: Step values 6 and 7 select no switch, so all gates are inactive.
- R4: In explicit mode (`use_pattern`=1), switch `pwm_sw` follows `pwm_in` and switch `on_sw` is held on. An index of 6 or 7 selects no switch.
- R5: The routing is sampled only on a clock where `commute` is high. Changing `step`, `use_pattern`, `pwm_sw` or `on_sw` at any other time leaves the gates unchanged.
- R6: If both switches of one leg are requested at once, both are driven off for as long as the conflict lasts.
- R7: When a switch's request rises, its gate turns on `dead` clocks later than a turn-off would take. A turn-off appears on the output one clock after the request falls.
- R8: A `pol` bit of 1 makes that output active-low (inverted). A bit of 0 makes it active-high.
- R9: When `enable` is low at a clock edge, every `gate` bit equals its `pol` bit after that edge.
- R10: At most two switches are driven at any time, and at most one of them carries PWM.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM waveform to be steered |
| commute | input | 1 | Commutation pulse; loads the routing |
| use_pattern | input | 1 | 1: explicit switch indices, 0: step index |
| step | input | 3 | Commutation step 0..5 |
| pwm_sw | input | 3 | Explicit index of the PWM switch |
| on_sw | input | 3 | Explicit index of the held-on switch |
| dead | input | DT_W | Dead time in clocks |
| pol | input | 6 | Per-output polarity, 1 = active-low |
| enable | input | 1 | Master output enable |
| gate | output | 6 | Gate drive outputs |

## Verification
On every cycle, the assertions check that the two internal drives of a leg are never both high. They also check that no more than two switches are driven, and that the routing register holds between commutation pulses. They further check that a disabled or unrequested output sits at its inactive level. Only the bench scenarios show the decoded step masks, the explicit and out-of-range indices, the exact turn-on delay for a given dead time, and the effect of polarity on a live pattern.

// File: rtl/steer_pkg.sv
package steer_pkg;
    localparam int LEGS  = 3;
    localparam int NSW   = 2 * LEGS;
    localparam int IDX_W = 3;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] pwm_sw;
        logic [IDX_W-1:0] on_sw;
    } route_t;

    // one-hot switch mask, empty for indices beyond the last switch
    function automatic logic [NSW-1:0] sw_mask(logic [IDX_W-1:0] idx);
        logic [NSW-1:0] m;
        m = NSW'(1) << idx;
        if (int'(idx) >= NSW) m = '0;
        return m;
    endfunction

    // six-step decode: PWM on high side of one leg, low side of another held on
    function automatic route_t step_route(logic [2:0] s);
        route_t r;
        int h;
        int l;
        h = int'(s[2:1]);
        l = (h + 1 + int'(s[0])) % LEGS;
        r.valid  = (int'(s) < NSW);
        r.pwm_sw = IDX_W'(2 * h);
        r.on_sw  = IDX_W'(2 * l + 1);
        return r;
    endfunction
endpackage

// File: rtl/route_latch.sv
module route_latch
    import steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             commute,
    input  logic             use_pattern,
    input  logic [2:0]       step,
    input  logic [IDX_W-1:0] pwm_sw,
    input  logic [IDX_W-1:0] on_sw,
    output route_t           q
);
    route_t nxt;

    always_comb begin
        if (use_pattern) begin
            nxt.valid  = 1'b1;
            nxt.pwm_sw = pwm_sw;
            nxt.on_sw  = on_sw;
        end else begin
            nxt = step_route(step);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (commute) q <= nxt;
    end
endmodule

// File: rtl/dead_leg.sv
module dead_leg #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      req,
    input  logic [DT_W-1:0] dead,
    output logic [1:0]      drive
);
    logic [1:0] ok_req;

    // a request for both switches of the leg turns both off
    assign ok_req = (&req) ? 2'b00 : req;

    for (genvar j = 0; j < 2; j++) begin : g_sw
        logic [DT_W-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst || !ok_req[j]) cnt <= '0;
            else if (cnt < dead) cnt <= cnt + 1'b1;
        end
        assign drive[j] = ok_req[j] && (cnt >= dead);
    end
endmodule

// File: rtl/gate_steer.sv
module gate_steer
    import steer_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_in,
    input  logic             commute,
    input  logic             use_pattern,
    input  logic [2:0]       step,
    input  logic [IDX_W-1:0] pwm_sw,
    input  logic [IDX_W-1:0] on_sw,
    input  logic [DT_W-1:0]  dead,
    input  logic [NSW-1:0]   pol,
    input  logic             enable,
    output logic [NSW-1:0]   gate
);
    route_t         lat_q;
    logic [NSW-1:0] req;
    logic [NSW-1:0] drive;

    route_latch u_latch (
        .clk(clk), .rst(rst), .commute(commute), .use_pattern(use_pattern),
        .step(step), .pwm_sw(pwm_sw), .on_sw(on_sw), .q(lat_q)
    );

    always_comb begin
        req = '0;
        if (lat_q.valid)
            req = sw_mask(lat_q.on_sw) | (pwm_in ? sw_mask(lat_q.pwm_sw) : '0);
    end

    for (genvar k = 0; k < LEGS; k++) begin : g_leg
        dead_leg #(.DT_W(DT_W)) u_leg (
            .clk(clk), .rst(rst), .req(req[2*k+1:2*k]), .dead(dead),
            .drive(drive[2*k+1:2*k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) gate <= pol;
        else gate <= drive ^ pol;
    end
endmodule

// File: rtl/steer_checker.sv
module steer_checker
    import steer_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           enable,
    input logic           commute,
    input logic [NSW-1:0] pol,
    input logic [NSW-1:0] gate,
    input logic [NSW-1:0] req,
    input logic [NSW-1:0] drive,
    input route_t         lat_q
);
    for (genvar k = 0; k < LEGS; k++) begin : g_leg
        a_r6_leg_exclusive: assert property (@(posedge clk) disable iff (rst)
            !(drive[2*k] && drive[2*k+1]));
    end

    a_r10_two_max: assert property (@(posedge clk) disable iff (rst)
        $countones(drive) <= 2);

    a_r5_route_hold: assert property (@(posedge clk) disable iff (rst)
        !commute |=> $stable(lat_q));

    a_r9_disable_idle: assert property (@(posedge clk) disable iff (rst)
        $past(!enable) |-> gate == $past(pol));

    for (genvar i = 0; i < NSW; i++) begin : g_sw
        a_r7_fall_fast: assert property (@(posedge clk) disable iff (rst)
            $past(!req[i]) |-> gate[i] == $past(pol[i]));
    end
endmodule

bind gate_steer steer_checker i_chk (
    .clk(clk), .rst(rst), .enable(enable), .commute(commute), .pol(pol),
    .gate(gate), .req(req), .drive(drive), .lat_q(lat_q)
);

// File: tb/test_gate_steer.sv
`timescale 1ns/1ps
module test_gate_steer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwm_in = 1'b0;
    logic       commute = 1'b0;
    logic       use_pattern = 1'b0;
    logic [2:0] step = 3'd0;
    logic [2:0] pwm_sw = 3'd0;
    logic [2:0] on_sw = 3'd0;
    logic [7:0] dead = 8'd0;
    logic [5:0] pol = 6'b000101;
    logic       enable = 1'b1;
    logic [5:0] gate;
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    gate_steer i_gate_steer (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .commute(commute),
        .use_pattern(use_pattern), .step(step), .pwm_sw(pwm_sw), .on_sw(on_sw),
        .dead(dead), .pol(pol), .enable(enable), .gate(gate)
    );

    typedef struct packed {
        logic [2:0] st;
        logic       pw;
        logic [5:0] exp;
    } vec_t;

    // R2 and R3: step decode with PWM high and low
    localparam vec_t VT [12] = '{
        '{3'd0, 1'b1, 6'b001001}, '{3'd1, 1'b1, 6'b100001},
        '{3'd2, 1'b1, 6'b100100}, '{3'd3, 1'b1, 6'b000110},
        '{3'd4, 1'b1, 6'b010010}, '{3'd5, 1'b1, 6'b011000},
        '{3'd0, 1'b0, 6'b001000}, '{3'd3, 1'b0, 6'b000010},
        '{3'd5, 1'b0, 6'b001000}, '{3'd6, 1'b1, 6'b000000},
        '{3'd7, 1'b1, 6'b000000}, '{3'd2, 1'b0, 6'b100000}
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: gate=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic do_commute;
        commute = 1'b1;
        cyc(1);
        commute = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(3);
        check("R1 reset level", gate, 6'b000101);
        rst = 1'b0;
        pol = 6'b000000;
        pwm_in = 1'b1;
        cyc(3);
        check("R1 idle before commute", gate, 6'b000000);

        for (int v = 0; v < 12; v++) begin
            step = VT[v].st;
            pwm_in = VT[v].pw;
            do_commute();
            cyc(1);
            check($sformatf("R2/R3 step %0d pwm %0d", VT[v].st, VT[v].pw), gate, VT[v].exp);
        end

        // R5: no commute, step change ignored
        step = 3'd0; pwm_in = 1'b1;
        do_commute(); cyc(1);
        step = 3'd4; use_pattern = 1'b1; pwm_sw = 3'd2; on_sw = 3'd5;
        cyc(4);
        check("R5 route held without commute", gate, 6'b001001);

        // R4: explicit pattern
        do_commute(); cyc(1);
        check("R4 explicit pwm2 on5", gate, 6'b100100);
        pwm_sw = 3'd7; on_sw = 3'd1;
        do_commute(); cyc(1);
        check("R4 explicit no pwm switch", gate, 6'b000010);

        // R6: same-leg conflict
        pwm_sw = 3'd0; on_sw = 3'd1;
        do_commute(); cyc(1);
        check("R6 conflict both off", gate, 6'b000000);
        pwm_in = 1'b0; cyc(2);
        check("R6 conflict clears", gate, 6'b000010);

        // R7: dead time on rising edge, immediate fall
        use_pattern = 1'b0; step = 3'd0; pwm_in = 1'b0; dead = 8'd3;
        do_commute(); cyc(6);
        check("R7 held switch after dead time", gate, 6'b001000);
        pwm_in = 1'b1;
        cyc(3);
        check("R7 still off inside dead time", gate, 6'b001000);
        cyc(1);
        check("R7 on after dead time", gate, 6'b001001);
        pwm_in = 1'b0;
        cyc(1);
        check("R7 fall after one clock", gate, 6'b001000);

        // R8: polarity inversion
        dead = 8'd0; pwm_in = 1'b1; pol = 6'b111111;
        cyc(2);
        check("R8 all active-low", gate, 6'b110110);
        pol = 6'b000001;
        cyc(1);
        check("R8 one inverted", gate, 6'b001000);

        // R9: enable low
        enable = 1'b0;
        cyc(1);
        check("R9 disabled inactive", gate, 6'b000001);
        pwm_in = 1'b0; pol = 6'b100000;
        cyc(1);
        check("R9 follows polarity", gate, 6'b100000);
        enable = 1'b1; pol = 6'b000000; pwm_in = 1'b1;
        cyc(1);
        check("R9 re-enabled / R10 two switches", gate, 6'b001001);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule